// File: doc/BRIEF.md
# Vectored Interrupt Arbiter

This block gathers up to 60 level-sensitive interrupt request lines, each with its own enable bit, pending bit and 4-bit urgency value. In every cycle it finds the most urgent request that is both pending and enabled. It then compares that request with the urgency of the handler that is currently running. When the request wins, the block opens an entry window toward the core. The window carries an entry request and the vector number, which is the channel index.

A stack of running handlers supports nesting. A later request that is more urgent can preempt the running handler. A request that arrives during an open entry window can take the window over if it is more urgent than the request already chosen. When a handler exits, the stack is popped. If a waiting request can preempt the level being returned to, a shorter chained entry window opens in the very next cycle. The interrupted level does not run again first.

Software reaches the enable, pending and urgency state through a register port with valid/ready on both the request and the response. A read response stays on the port until it is accepted. While a response waits, the request side stalls. Writes return no response.

Top module: `vec_irq_arbiter`

## Requirements
- R1: After reset all enables, pending bits and urgency fields read 0, no handler is active (`act_depth` 0) and `entry_req` is low.
- R2: A channel's pending bit sets at any clock edge where its request line is high. Writing 1s to word 2 (channels 0-31) or word 3 (channels 32-59) sets pending bits. Writing 1s to word 4 or word 5 clears them. The bit also clears at the edge where that channel's handler starts. A clear wins over a set in the same cycle. Words 2-5 read back the pending bits.
- R3: Among the requests that are pending and enabled, the lowest urgency value wins. On a tie the lowest channel number wins. A pending channel that is disabled is never selected.
- R4: A normal entry window keeps `entry_req` high for 12 cycles with the vector on `entry_vec`. `handler_start` pulses in the last of those cycles. At the next edge the handler is pushed, so `act_depth` rises by one and `run_vec` and `run_prio` show it.
- R5: A new entry starts only when the winner's value is strictly lower than `run_prio`, or when no handler is active. A request of equal value waits.
- R6: During a window, a request whose value is strictly lower than the chosen one replaces the vector. The window length does not change. A request that is not more urgent leaves the vector alone.
- R7: Up to 16 handlers nest. A pulse on `exit_i` pops the top one, and `run_vec` and `run_prio` return to the handler below.
- R8: If, on an exit, a waiting request beats the level being returned to, a chained window opens at the same edge. In that window `entry_req` and `entry_chain` are high for 6 cycles.
- R9: Word 0 holds the enables for channels 0-31 and word 1 holds those for channels 32-59; both read back. Word 8+k holds the urgency of channel 8k+j in bits [4j+3:4j]. Unmapped words read 0.
- R10: `reg_req_ready` is low while a read response is held with `reg_rsp_ready` low. `reg_rsp_data` stays stable until the response is accepted.
- R11: `exit_i` has no effect while no handler is active or while an entry window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 60 | Level request lines |
| reg_req_valid | input | 1 | Register request valid |
| reg_req_ready | output | 1 | Register request ready |
| reg_req_write | input | 1 | 1 = write, 0 = read |
| reg_req_addr | input | 6 | Word address |
| reg_req_wdata | input | 32 | Write data |
| reg_rsp_valid | output | 1 | Read response valid |
| reg_rsp_ready | input | 1 | Read response accepted |
| reg_rsp_data | output | 32 | Read data |
| entry_req | output | 1 | Entry window open |
| entry_vec | output | 6 | Vector being entered |
| entry_chain | output | 1 | Window is a chained entry |
| handler_start | output | 1 | Last cycle of the window |
| exit_i | input | 1 | Running handler returns (pulse) |
| run_active | output | 1 | At least one handler active |
| run_vec | output | 6 | Vector of the running handler |
| run_prio | output | 4 | Urgency of the running handler |
| act_depth | output | 5 | Number of nested handlers |

## Verification
Selection is tried with a single request from idle and with simultaneous requests of equal value. Those requests include a more urgent one that is disabled, which separates the tie-break rule from the enable mask. Preemption is tried with an equal-value request, which must wait, and with a strictly more urgent one, which must nest. Two late arrivals are injected into one window: one more urgent and one less urgent than the current choice. They show that replacement happens and that it only ever improves the vector. A chain of exits is driven against a known set of waiting requests, so each exit produces a chained entry, a plain return, or a chained entry into an idle level. Each outcome is told apart by its window length, its chain flag and the depth it leaves behind.

// File: rtl/virq_pkg.sv
package virq_pkg;
  localparam int PRIO_W = 4;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;

  // word addresses of the register port
  localparam int A_EN_LO   = 0;
  localparam int A_EN_HI   = 1;
  localparam int A_PSET_LO = 2;
  localparam int A_PSET_HI = 3;
  localparam int A_PCLR_LO = 4;
  localparam int A_PCLR_HI = 5;
  localparam int A_PRIO    = 8;

  // threshold meaning "nothing running": any request beats it
  localparam logic [PRIO_W:0] NO_PRIO = (PRIO_W+1)'(1 << PRIO_W);
endpackage

// File: rtl/virq_regs.sv
module virq_regs
  import virq_pkg::*;
#(
  parameter int NUM_IRQ = 60,
  localparam int CH_W = $clog2(NUM_IRQ)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IRQ-1:0]        irq_i,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [DATA_W-1:0]         req_wdata,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic [DATA_W-1:0]         rsp_data,
  input  logic                      take_valid,
  input  logic [CH_W-1:0]           take_ch,
  output logic [NUM_IRQ-1:0]        en_o,
  output logic [NUM_IRQ-1:0]        pend_o,
  output logic [NUM_IRQ*PRIO_W-1:0] prio_o
);
  logic [NUM_IRQ-1:0] en_q, en_n, pend_q, pend_n, set_m, clr_m, take_m;
  logic [PRIO_W-1:0]  prio_q [NUM_IRQ];
  logic [PRIO_W-1:0]  prio_n [NUM_IRQ];
  logic               acc, wr;
  logic [DATA_W-1:0]  rd;
  logic [63:0]        en64, pend64;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign wr        = acc && req_write;

  always_comb begin
    en_n   = en_q;
    set_m  = '0;
    clr_m  = '0;
    take_m = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      prio_n[i] = prio_q[i];
      if (wr && req_addr == ADDR_W'(A_EN_LO + i / 32))
        en_n[i] = req_wdata[i % 32];
      if (wr && req_addr == ADDR_W'(A_PSET_LO + i / 32))
        set_m[i] = req_wdata[i % 32];
      if (wr && req_addr == ADDR_W'(A_PCLR_LO + i / 32))
        clr_m[i] = req_wdata[i % 32];
      if (wr && req_addr == ADDR_W'(A_PRIO + i / 8))
        prio_n[i] = req_wdata[(i % 8) * PRIO_W +: PRIO_W];
      if (take_valid && take_ch == CH_W'(i))
        take_m[i] = 1'b1;
    end
    // clears (software or service) win over any set in the same cycle
    pend_n = (pend_q | irq_i | set_m) & ~clr_m & ~take_m;
  end

  assign en64   = 64'(en_q);
  assign pend64 = 64'(pend_q);

  always_comb begin
    rd = '0;
    case (req_addr)
      ADDR_W'(A_EN_LO):   rd = en64[31:0];
      ADDR_W'(A_EN_HI):   rd = en64[63:32];
      ADDR_W'(A_PSET_LO),
      ADDR_W'(A_PCLR_LO): rd = pend64[31:0];
      ADDR_W'(A_PSET_HI),
      ADDR_W'(A_PCLR_HI): rd = pend64[63:32];
      default: begin
        for (int i = 0; i < NUM_IRQ; i++)
          if (req_addr == ADDR_W'(A_PRIO + i / 8))
            rd[(i % 8) * PRIO_W +: PRIO_W] = prio_q[i];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= '0;
      pend_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      for (int i = 0; i < NUM_IRQ; i++) prio_q[i] <= '0;
    end else begin
      en_q   <= en_n;
      pend_q <= pend_n;
      for (int i = 0; i < NUM_IRQ; i++) prio_q[i] <= prio_n[i];
      if (acc && !req_write) begin
        rsp_valid <= 1'b1;
        rsp_data  <= rd;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_prio_out
    assign prio_o[g*PRIO_W +: PRIO_W] = prio_q[g];
  end

  // R2: a channel taken into service is no longer pending after that edge
  a_r2_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |=> !pend_q[$past(take_ch)]);

  // R10: a waiting response holds its data until accepted
  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

// File: rtl/virq_select.sv
module virq_select
  import virq_pkg::*;
#(
  parameter int NUM_IRQ = 60,
  localparam int CH_W = $clog2(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0]        req_i,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
  output logic                      win_valid,
  output logic [CH_W-1:0]           win_ch,
  output logic [PRIO_W-1:0]         win_prio
);
  // linear scan; strict compare keeps the lowest index on ties
  always_comb begin
    win_valid = 1'b0;
    win_ch    = '0;
    win_prio  = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (req_i[i] && (!win_valid || prio_i[i*PRIO_W +: PRIO_W] < win_prio)) begin
        win_valid = 1'b1;
        win_ch    = CH_W'(i);
        win_prio  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/virq_stack.sv
module virq_stack
  import virq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CH_W  = 6,
  localparam int DW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [CH_W-1:0]   push_ch,
  input  logic [PRIO_W-1:0] push_prio,
  input  logic              pop,
  output logic [DW-1:0]     depth_o,
  output logic [CH_W-1:0]   top_ch,
  output logic [PRIO_W-1:0] top_prio,
  output logic [PRIO_W-1:0] next_prio
);
  logic [CH_W-1:0]   ch_q [DEPTH];
  logic [PRIO_W-1:0] pr_q [DEPTH];
  logic [DW-1:0]     depth_q;
  logic [IW-1:0]     top_idx, next_idx, push_idx;

  assign top_idx  = IW'(depth_q - DW'(1));
  assign next_idx = IW'(depth_q - DW'(2));
  assign push_idx = IW'(depth_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        ch_q[i] <= '0;
        pr_q[i] <= '0;
      end
    end else if (push) begin
      ch_q[push_idx] <= push_ch;
      pr_q[push_idx] <= push_prio;
      depth_q        <= depth_q + DW'(1);
    end else if (pop && depth_q != '0) begin
      depth_q <= depth_q - DW'(1);
    end
  end

  assign depth_o   = depth_q;
  assign top_ch    = ch_q[top_idx];
  assign top_prio  = pr_q[top_idx];
  assign next_prio = pr_q[next_idx];

  // R7: never push past the configured depth
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> depth_q < DW'(DEPTH));

  // R7: entry and exit never land on the same edge
  a_r7_push_pop_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));

  // R5: each nested handler is strictly more urgent than the one below
  a_r5_nest_ordered: assert property (@(posedge clk) disable iff (!rst_n)
    (push && depth_q != '0) |-> push_prio < top_prio);
endmodule

// File: rtl/vec_irq_arbiter.sv
module vec_irq_arbiter
  import virq_pkg::*;
#(
  parameter int NUM_IRQ     = 60,
  parameter int STACK_DEPTH = 16,
  parameter int ENTRY_CYC   = 12,
  parameter int CHAIN_CYC   = 6,
  localparam int CH_W = $clog2(NUM_IRQ),
  localparam int DW   = $clog2(STACK_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               reg_req_valid,
  output logic               reg_req_ready,
  input  logic               reg_req_write,
  input  logic [ADDR_W-1:0]  reg_req_addr,
  input  logic [DATA_W-1:0]  reg_req_wdata,
  output logic               reg_rsp_valid,
  input  logic               reg_rsp_ready,
  output logic [DATA_W-1:0]  reg_rsp_data,
  output logic               entry_req,
  output logic [CH_W-1:0]    entry_vec,
  output logic               entry_chain,
  output logic               handler_start,
  input  logic               exit_i,
  output logic               run_active,
  output logic [CH_W-1:0]    run_vec,
  output logic [PRIO_W-1:0]  run_prio,
  output logic [DW-1:0]      act_depth
);
  localparam int WIN_MAX = (ENTRY_CYC > CHAIN_CYC) ? ENTRY_CYC : CHAIN_CYC;
  localparam int CW      = $clog2(WIN_MAX + 1);

  logic [NUM_IRQ-1:0]        en, pend;
  logic [NUM_IRQ*PRIO_W-1:0] prio_flat;
  logic                      win_valid;
  logic [CH_W-1:0]           win_ch;
  logic [PRIO_W-1:0]         win_prio;
  logic [DW-1:0]             depth;
  logic [CH_W-1:0]           top_ch;
  logic [PRIO_W-1:0]         top_prio, next_prio;

  logic                      in_win_q, chain_q;
  logic [CW-1:0]             cnt_q, last_cnt;
  logic [CH_W-1:0]           cand_ch_q;
  logic [PRIO_W-1:0]         cand_prio_q;
  logic [PRIO_W:0]           cur_thr, pop_thr, eff_thr;
  logic                      exit_ok, can_enter, done, better;

  virq_regs #(.NUM_IRQ(NUM_IRQ)) u_regs (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i),
    .req_valid(reg_req_valid), .req_ready(reg_req_ready),
    .req_write(reg_req_write), .req_addr(reg_req_addr),
    .req_wdata(reg_req_wdata), .rsp_valid(reg_rsp_valid),
    .rsp_ready(reg_rsp_ready), .rsp_data(reg_rsp_data),
    .take_valid(done), .take_ch(cand_ch_q),
    .en_o(en), .pend_o(pend), .prio_o(prio_flat)
  );

  virq_select #(.NUM_IRQ(NUM_IRQ)) u_sel (
    .req_i(pend & en), .prio_i(prio_flat),
    .win_valid(win_valid), .win_ch(win_ch), .win_prio(win_prio)
  );

  virq_stack #(.DEPTH(STACK_DEPTH), .CH_W(CH_W)) u_stack (
    .clk(clk), .rst_n(rst_n),
    .push(done), .push_ch(cand_ch_q), .push_prio(cand_prio_q),
    .pop(exit_ok), .depth_o(depth),
    .top_ch(top_ch), .top_prio(top_prio), .next_prio(next_prio)
  );

  // thresholds: level now running, and level left after a pop
  assign cur_thr = (depth == '0) ? NO_PRIO : {1'b0, top_prio};
  assign pop_thr = (depth >= DW'(2)) ? {1'b0, next_prio} : NO_PRIO;

  assign exit_ok   = exit_i && !in_win_q && depth != '0;
  assign eff_thr   = exit_ok ? pop_thr : cur_thr;
  assign can_enter = !in_win_q && win_valid && ({1'b0, win_prio} < eff_thr) &&
                     (exit_ok || depth < DW'(STACK_DEPTH));

  assign last_cnt = chain_q ? CW'(CHAIN_CYC - 1) : CW'(ENTRY_CYC - 1);
  assign done     = in_win_q && cnt_q == last_cnt;
  assign better   = in_win_q && !done && win_valid && win_prio < cand_prio_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_win_q    <= 1'b0;
      chain_q     <= 1'b0;
      cnt_q       <= '0;
      cand_ch_q   <= '0;
      cand_prio_q <= '0;
    end else if (!in_win_q) begin
      if (can_enter) begin
        in_win_q    <= 1'b1;
        cnt_q       <= '0;
        cand_ch_q   <= win_ch;
        cand_prio_q <= win_prio;
        chain_q     <= exit_ok;
      end
    end else if (done) begin
      in_win_q <= 1'b0;
      chain_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
      if (better) begin
        cand_ch_q   <= win_ch;
        cand_prio_q <= win_prio;
      end
    end
  end

  assign entry_req     = in_win_q;
  assign entry_vec     = cand_ch_q;
  assign entry_chain   = in_win_q && chain_q;
  assign handler_start = done;
  assign run_active    = depth != '0;
  assign run_vec       = run_active ? top_ch : '0;
  assign run_prio      = top_prio;
  assign act_depth     = depth;

  // R3: the selected channel is pending and enabled; no pick means none eligible
  a_r3_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (pend[win_ch] && en[win_ch]));
  a_r3_none_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid |-> ((pend & en) == '0));

  // R4: the window closes after the start pulse and the handler is pushed
  a_r4_start_pushes: assert property (@(posedge clk) disable iff (!rst_n)
    handler_start |=> (!entry_req && act_depth == $past(act_depth) + DW'(1)));

  // R5: a fresh (unchained) entry is strictly more urgent than what runs
  a_r5_strict_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(entry_req) && !entry_chain) |-> (!run_active || cand_prio_q < run_prio));

  // R6: a replaced vector is always more urgent than the one it replaced
  a_r6_only_improves: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_req && $past(entry_req) && entry_vec != $past(entry_vec))
      |-> cand_prio_q < $past(cand_prio_q));

  // R8: a chained window opens on the same edge that pops the stack
  a_r8_chain_pops: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(entry_req) && entry_chain) |-> act_depth == $past(act_depth) - DW'(1));

  // R11: exit during an open window leaves the stack alone
  a_r11_exit_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_i && entry_req && !handler_start) |=> act_depth == $past(act_depth));
endmodule

// File: tb/sim_vec_irq_arbiter.sv
module sim_vec_irq_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [59:0] irq_i = '0;
  logic        reg_req_valid = 1'b0, reg_req_write = 1'b0, reg_rsp_ready = 1'b1;
  logic [5:0]  reg_req_addr = '0;
  logic [31:0] reg_req_wdata = '0;
  logic        reg_req_ready, reg_rsp_valid;
  logic [31:0] reg_rsp_data;
  logic        entry_req, entry_chain, handler_start, run_active;
  logic [5:0]  entry_vec, run_vec;
  logic [3:0]  run_prio;
  logic [4:0]  act_depth;
  logic        exit_i = 1'b0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  vec_irq_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i),
    .reg_req_valid(reg_req_valid), .reg_req_ready(reg_req_ready),
    .reg_req_write(reg_req_write), .reg_req_addr(reg_req_addr),
    .reg_req_wdata(reg_req_wdata), .reg_rsp_valid(reg_rsp_valid),
    .reg_rsp_ready(reg_rsp_ready), .reg_rsp_data(reg_rsp_data),
    .entry_req(entry_req), .entry_vec(entry_vec), .entry_chain(entry_chain),
    .handler_start(handler_start), .exit_i(exit_i), .run_active(run_active),
    .run_vec(run_vec), .run_prio(run_prio), .act_depth(act_depth)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    reg_req_valid = 1'b1; reg_req_write = 1'b1;
    reg_req_addr = 6'(addr); reg_req_wdata = data;
    while (!reg_req_ready) @(negedge clk);
    @(negedge clk);
    reg_req_valid = 1'b0; reg_req_write = 1'b0;
  endtask

  task automatic reg_rd(input int addr, output logic [31:0] data);
    @(negedge clk);
    reg_req_valid = 1'b1; reg_req_write = 1'b0; reg_req_addr = 6'(addr);
    while (!reg_req_ready) @(negedge clk);
    @(negedge clk);
    reg_req_valid = 1'b0;
    data = reg_rsp_valid ? reg_rsp_data : 32'hDEAD_BEEF;
  endtask

  task automatic pulse_exit();
    @(negedge clk); exit_i = 1'b1;
    @(negedge clk); exit_i = 1'b0;
  endtask

  // follow one entry window; optional late pulses / exit at given window cycles
  task automatic run_window(input int ca, input int cha, input int cb, input int chb,
                            input int cex, output int len, output int vec, output int chain);
    int t = 0;
    len = 0; vec = -1; chain = 0;
    while (!entry_req && t < 40) begin @(negedge clk); t++; end
    chain = int'(entry_chain);
    while (entry_req && len < 40) begin
      len++;
      irq_i = '0; exit_i = 1'b0;
      if (len == ca) irq_i[cha] = 1'b1;
      if (len == cb) irq_i[chb] = 1'b1;
      if (len == cex) exit_i = 1'b1;
      if (handler_start) vec = int'(entry_vec);
      @(negedge clk);
    end
    irq_i = '0; exit_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 entry_req", entry_req, 0);
    chk("R1 act_depth", act_depth, 0);
    reg_rd(0, d); chk("R1 enable lo", d, 0);
    reg_rd(3, d); chk("R1 pending hi", d, 0);
    reg_rd(15, d); chk("R1 prio word", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    reg_wr(0, 32'hA5A5_0001); reg_rd(0, d); chk("R9 enable lo rw", d, 32'hA5A5_0001);
    reg_wr(1, 32'hFFFF_FFFF); reg_rd(1, d); chk("R9 enable hi 28 bits", d, 32'h0FFF_FFFF);
    reg_wr(9, 32'h1234_5678); reg_rd(9, d); chk("R9 prio word rw", d, 32'h1234_5678);
    reg_rd(7, d); chk("R9 unmapped word", d, 0);
    reg_wr(0, 0); reg_wr(1, 0); reg_wr(9, 0);
    reg_wr(2, 32'h0010_0000); reg_rd(4, d); chk("R2 sw set ch20", d, 32'h0010_0000);
    reg_wr(4, 32'h0010_0000); reg_rd(2, d); chk("R2 sw clear ch20", d, 0);
    @(negedge clk); irq_i[33] = 1'b1; @(negedge clk); irq_i[33] = 1'b0;
    reg_rd(3, d); chk("R2 level set ch33 (disabled)", d, 32'h2);
    reg_wr(5, 32'h2); reg_rd(3, d); chk("R2 clear hi", d, 0);
  endtask

  task automatic t_backpressure();
    logic [31:0] d0;
    reg_wr(10, 32'h0000_0C00);
    @(negedge clk);
    reg_rsp_ready = 1'b0;
    reg_req_valid = 1'b1; reg_req_write = 1'b0; reg_req_addr = 6'd10;
    @(negedge clk);
    chk("R10 rsp valid", reg_rsp_valid, 1);
    d0 = reg_rsp_data;
    chk("R10 rsp data", d0, 32'h0000_0C00);
    reg_req_addr = 6'd0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 ready low while held", reg_req_ready, 0);
      chk("R10 data stable", reg_rsp_data, d0);
    end
    reg_rsp_ready = 1'b1;
    @(negedge clk);
    reg_req_valid = 1'b0;
    chk("R10 second read answered", reg_rsp_data, 0);
    reg_wr(10, 0);
  endtask

  task automatic t_single();
    int len, vec, ch;
    logic [31:0] d;
    reg_wr(8, 32'h0030_0000);   // ch5 value 3
    reg_wr(0, 32'h0000_0020);   // enable ch5
    @(negedge clk); irq_i[5] = 1'b1; @(negedge clk); irq_i[5] = 1'b0;
    run_window(0, 0, 0, 0, 0, len, vec, ch);
    chk("R4 window length", len, 12);
    chk("R4 start vector", vec, 5);
    chk("R4 not chained", ch, 0);
    chk("R4 depth after start", act_depth, 1);
    chk("R4 run_vec", run_vec, 5);
    chk("R4 run_prio", run_prio, 3);
    reg_rd(2, d); chk("R2 taken clears pending", d, 0);
    pulse_exit();
    chk("R7 exit pops", act_depth, 0);
    pulse_exit();
    chk("R11 exit idle depth", act_depth, 0);
    chk("R11 exit idle no entry", entry_req, 0);
  endtask

  task automatic t_nest_chain();
    int len, vec, ch, hits;
    logic [31:0] d;
    reg_wr(8, 32'h0000_7000);   // ch3 value 7
    reg_wr(9, 32'h0000_0700);   // ch10 value 7
    reg_wr(10, 32'h0002_0000);  // ch20 value 2 (stays disabled)
    reg_wr(13, 32'h0000_0415);  // ch40=5 ch41=1 ch42=4
    reg_wr(0, 32'h0000_0408);   // enable ch3, ch10
    reg_wr(1, 32'h0000_0700);   // enable ch40-42
    reg_wr(2, 32'h0010_0408);   // pend ch3, ch10, ch20 at once
    run_window(0, 0, 0, 0, 0, len, vec, ch);
    chk("R3 tie picks lower channel, disabled skipped", vec, 3);
    chk("R4 length", len, 12);
    hits = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (entry_req) hits++; end
    chk("R5 equal value waits", hits, 0);
    @(negedge clk); irq_i[40] = 1'b1; @(negedge clk); irq_i[40] = 1'b0;
    run_window(2, 41, 6, 42, 5, len, vec, ch);
    chk("R6 late arrival replaces", vec, 41);
    chk("R6 window length unchanged", len, 12);
    chk("R11 exit in window ignored, depth", act_depth, 2);
    chk("R5 nested run_prio", run_prio, 1);
    pulse_exit();
    chk("R8 chained after exit", entry_chain, 1);
    chk("R8 popped", act_depth, 1);
    run_window(0, 0, 0, 0, 0, len, vec, ch);
    chk("R8 chain vec", vec, 42);
    chk("R8 chain length", len, 6);
    chk("R8 chain depth", act_depth, 2);
    pulse_exit();
    run_window(0, 0, 0, 0, 0, len, vec, ch);
    chk("R8 second chain vec", vec, 40);
    chk("R8 second chain flag", ch, 1);
    pulse_exit();
    chk("R7 plain return no window", entry_req, 0);
    chk("R7 restored run_vec", run_vec, 3);
    chk("R7 restored run_prio", run_prio, 7);
    chk("R7 restored depth", act_depth, 1);
    pulse_exit();
    run_window(0, 0, 0, 0, 0, len, vec, ch);
    chk("R8 chain from last level vec", vec, 10);
    chk("R8 chain from last level length", len, 6);
    pulse_exit();
    chk("R7 back to idle", act_depth, 0);
    reg_rd(2, d); chk("R3 disabled ch20 still pending", d, 32'h0010_0000);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_backpressure();
    t_single();
    t_nest_chain();
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule